// File: doc/BRIEF.md
# Tamper Event Counter with Polled Sampling

This block counts events seen on an external contact input, such as a case-open switch. It holds a 16-bit event count and a small control register, both reachable through a byte-wide register bus. In continuous mode the contact input passes through a two-flop synchroniser. One count is made for each edge of the selected polarity.

A low-power polled mode can be enabled instead. The input is then looked at only once per sampling period. The period comes from dividing a slow real-time-clock enable (nominally 32.768 kHz) by a parameter, 4096 by default, which gives 125 ms. A rise between two samples adds one count. The divider only advances while the oscillator enable is on. Polled mode is only legal with battery-backed counting and rising-edge detection, so a write that turns it on forces those two settings.

A mode bit selects between two kinds of counting. With the bit at 1 (nonvolatile), counts are made only while the main supply is present. With the bit at 0 (battery-backed), counts are made whether or not the main supply is present.

Top module: `tamper_counter`

## Requirements
- R1: After reset the control register reads 01h: bit 7 mode is 0 (battery-backed), bit 1 poll is 0 and bit 0 polarity is 1 (rising). The count reads 0000h.
- R2: With poll at 0 and polarity at 1, each rising edge of `evt_in` adds exactly one to the count. The new value is readable two clock cycles after the first clock edge that sees the input high.
- R3: With poll at 0 and polarity at 0, each falling edge of `evt_in` adds exactly one, and rising edges add nothing.
- R4: The count is 16 bits wide and wraps from FFFFh to 0000h on an increment.
- R5: With mode bit 7 at 1, edges are not counted while `main_pwr` is 0 and are counted while it is 1. With the mode bit at 0, edges are counted regardless of `main_pwr`.
- R6: A write to the control register with bit 1 set stores poll=1, mode=0 and polarity=1, whatever bits 7 and 0 of the write data hold. The register then reads 03h.
- R7: With poll at 1, the synchronised input is sampled once every POLL_DIV cycles in which `rtc_tick` is high. One count is made when a sample is 1 and the previous sample was 0. Toggles between samples are not counted individually.
- R8: While `osc_en` is 0 the sampling divider holds and no polled sample is taken, so polled mode makes no count. Once `osc_en` returns to 1, polling resumes.
- R9: Register map on `reg_addr`: 0 is control (bits 7, 1 and 0; other bits read 0), 1 is count bits 7:0, 2 is count bits 15:8, and 3 reads 00h. A write to a count byte loads that byte, and in that cycle it takes priority over an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| main_pwr | input | 1 | High while the main supply is present |
| osc_en | input | 1 | Real-time-clock oscillator enable |
| rtc_tick | input | 1 | One-cycle enable at the slow clock rate |
| evt_in | input | 1 | Raw contact input |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |

## Verification
The embedded properties check on every cycle that:
- the control register can never hold poll=1 together with mode=1 or polarity=0;
- the count only holds or steps by one unless a count byte is written;
- the count holds in nonvolatile mode without main supply, and holds in polled mode outside sampling cycles;
- the divider freezes with the oscillator off.

Only the bench scenarios can show the behaviours that depend on input patterns, compared against a behavioural model: edge polarity, the exact count after bursts of pulses, wrap-around, the single count for a glitchy rise under polling, and polling resuming when the oscillator returns.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
package tc_pkg;
  localparam int REG_AW   = 2;
  localparam int REG_DW   = 8;
  localparam int NV_BIT   = 7;
  localparam int POLL_BIT = 1;
  localparam int POL_BIT  = 0;
  localparam logic [REG_AW-1:0] CTRL_ADDR   = 2'd0;
  localparam logic [REG_AW-1:0] CNT_LO_ADDR = 2'd1;

  typedef struct packed {
    logic nv_mode;
    logic poll_en;
    logic rise_edge;
  } tc_ctrl_t;

  localparam tc_ctrl_t CTRL_RESET = '{nv_mode: 1'b0, poll_en: 1'b0, rise_edge: 1'b1};
endpackage

// File: rtl/tc_rst_sync.sv
`timescale 1ns/1ps
module tc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = rs_q[STAGES-1];
endmodule

// File: rtl/tc_sync.sv
`timescale 1ns/1ps
module tc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/tc_poll_div.sv
`timescale 1ns/1ps
module tc_poll_div #(
  parameter int DIV = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic rtc_tick,
  output logic strobe
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q, div_d;
  logic          adv;

  always_comb begin
    adv    = osc_en && rtc_tick;
    strobe = adv && (div_q == LAST);
    div_d  = div_q;
    if (adv) div_d = strobe ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R8
  osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> $stable(div_q));

  // R7
  period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (div_q == '0));
endmodule

// File: rtl/tc_edge_qual.sv
`timescale 1ns/1ps
module tc_edge_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic s_in,
  input  logic poll_en,
  input  logic rise_edge,
  input  logic poll_strobe,
  output logic hit
);
  logic prev_q, prev_d;
  logic samp_q, samp_d;
  logic cont_hit, poll_hit;

  always_comb begin
    cont_hit = (s_in != prev_q) && (s_in == rise_edge);
    poll_hit = poll_strobe && s_in && !samp_q;
    hit      = poll_en ? poll_hit : cont_hit;
    prev_d   = s_in;
    samp_d   = (!poll_en || poll_strobe) ? s_in : samp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      samp_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      samp_q <= samp_d;
    end
  end

  // R2
  one_per_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !poll_en) |=> (poll_en || !hit || (rise_edge != $past(rise_edge))));
endmodule

// File: rtl/tamper_counter.sv
`timescale 1ns/1ps
module tamper_counter
  import tc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int POLL_DIV = 4096,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_pwr,
  input  logic              osc_en,
  input  logic              rtc_tick,
  input  logic              evt_in,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata
);
  localparam int NBYTES = CNT_W / REG_DW;

  logic             rst_s_n;
  logic             evt_s;
  logic             poll_strobe;
  logic             hit;
  logic             count_en;
  logic             cnt_wr;
  tc_ctrl_t         ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_wval;
  logic [NBYTES-1:0] byte_sel;

  tc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  tc_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .din(evt_in), .dout(evt_s));

  tc_poll_div #(.DIV(POLL_DIV)) u_div (
    .clk(clk), .rst_n(rst_s_n), .osc_en(osc_en), .rtc_tick(rtc_tick),
    .strobe(poll_strobe));

  tc_edge_qual u_qual (
    .clk(clk), .rst_n(rst_s_n), .s_in(evt_s), .poll_en(ctrl_q.poll_en),
    .rise_edge(ctrl_q.rise_edge), .poll_strobe(poll_strobe), .hit(hit));

  // byte lanes of the count
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign byte_sel[b] = reg_we && (reg_addr == REG_AW'(CNT_LO_ADDR + b));
    assign cnt_wval[b*REG_DW +: REG_DW] =
      byte_sel[b] ? reg_wdata : cnt_q[b*REG_DW +: REG_DW];
  end

  always_comb begin
    count_en = !ctrl_q.nv_mode || main_pwr;
    cnt_wr   = |byte_sel;
    cnt_d    = cnt_q;
    if (cnt_wr)                cnt_d = cnt_wval;
    else if (hit && count_en)  cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_we && reg_addr == CTRL_ADDR) begin
      if (reg_wdata[POLL_BIT])
        ctrl_d = '{nv_mode: 1'b0, poll_en: 1'b1, rise_edge: 1'b1};
      else
        ctrl_d = '{nv_mode: reg_wdata[NV_BIT], poll_en: 1'b0,
                   rise_edge: reg_wdata[POL_BIT]};
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q <= CTRL_RESET;
      cnt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_ADDR) begin
      reg_rdata[NV_BIT]   = ctrl_q.nv_mode;
      reg_rdata[POLL_BIT] = ctrl_q.poll_en;
      reg_rdata[POL_BIT]  = ctrl_q.rise_edge;
    end else begin
      for (int b = 0; b < NBYTES; b++)
        if (reg_addr == REG_AW'(CNT_LO_ADDR + b))
          reg_rdata = cnt_q[b*REG_DW +: REG_DW];
    end
  end

  // R6
  poll_forces_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ctrl_q.poll_en |-> (!ctrl_q.nv_mode && ctrl_q.rise_edge));

  // R5
  nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ctrl_q.nv_mode && !main_pwr && !cnt_wr) |=> $stable(cnt_q));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cnt_wr |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));

  // R7
  poll_gate_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ctrl_q.poll_en && !poll_strobe && !cnt_wr) |=> $stable(cnt_q));
endmodule

// File: tb/test_tamper_counter.sv
`timescale 1ns/1ps
module test_tamper_counter;
  localparam int DIV = 16;

  logic       clk = 1'b0;
  logic       rst_n, main_pwr, osc_en, rtc_tick, evt_in, reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  int n_chk = 0, n_fail = 0;
  int rot = 0;
  bit bg_on = 1'b0;

  always #10 clk = ~clk;

  tamper_counter #(.POLL_DIV(DIV)) i_tamper_counter (
    .clk(clk), .rst_n(rst_n), .main_pwr(main_pwr), .osc_en(osc_en),
    .rtc_tick(rtc_tick), .evt_in(evt_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  // behavioural reference model
  bit m_nv, m_poll, m_rise, m_s1, m_s2, m_prev, m_ps;
  int m_cnt, m_div;
  bit t_strobe, t_inc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_nv <= 0; m_poll <= 0; m_rise <= 1; m_cnt <= 0; m_div <= 0;
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_ps <= 0;
    end else begin
      t_strobe = osc_en && rtc_tick && (m_div == DIV - 1);
      if (osc_en && rtc_tick) m_div <= t_strobe ? 0 : m_div + 1;
      if (m_poll) t_inc = t_strobe && m_s2 && !m_ps;
      else        t_inc = (m_s2 != m_prev) && (m_s2 == m_rise);
      m_s1 <= evt_in; m_s2 <= m_s1; m_prev <= m_s2;
      if (!m_poll || t_strobe) m_ps <= m_s2;
      if (reg_we && reg_addr == 0) begin
        if (reg_wdata[1]) begin m_nv <= 0; m_poll <= 1; m_rise <= 1; end
        else begin m_nv <= reg_wdata[7]; m_poll <= 0; m_rise <= reg_wdata[0]; end
      end
      if (reg_we && reg_addr == 1)      m_cnt <= (m_cnt & 32'hFF00) | reg_wdata;
      else if (reg_we && reg_addr == 2) m_cnt <= (m_cnt & 32'h00FF) | (int'(reg_wdata) << 8);
      else if (t_inc && (!m_nv || main_pwr)) m_cnt <= (m_cnt + 1) & 32'hFFFF;
    end
  end

  function automatic int exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {m_nv, 5'b0, m_poll, m_rise};
      2'd1: return m_cnt & 8'hFF;
      2'd2: return (m_cnt >> 8) & 8'hFF;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // compare with the model on every clock
  always @(posedge clk) begin
    #5;
    if (bg_on) chk("R9 model compare", reg_rdata, exp_rd(reg_addr));
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_we = 0; reg_addr = 2'(rot); rot = (rot + 1) % 3;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    cyc(1);
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input int exp);
    @(negedge clk);
    reg_we = 0; reg_addr = a;
    @(posedge clk); #5;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse(input int hi, input int lo);
    evt_in = 1; cyc(hi);
    evt_in = 0; cyc(lo);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; main_pwr = 1; osc_en = 1; rtc_tick = 0; evt_in = 0;
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    #55 rst_n = 1;
    cyc(5);
    bg_on = 1; rtc_tick = 1;
    // R1 reset state
    rd(0, "R1 ctrl", 8'h01); rd(1, "R1 cnt lo", 0); rd(2, "R1 cnt hi", 0);
    // R2 rising edges
    for (int i = 0; i < 3; i++) pulse(3, 3);
    cyc(3); rd(1, "R2 rising count", 3);
    // R3 falling edges
    wr(0, 8'h00); rd(0, "R9 ctrl readback", 8'h00);
    pulse(3, 3); pulse(3, 3); cyc(3);
    rd(1, "R3 falling count", 5);
    // R4 wrap
    wr(0, 8'h01); wr(1, 8'hFF); wr(2, 8'hFF);
    rd(2, "R4 preload hi", 8'hFF);
    pulse(3, 3); cyc(3);
    rd(1, "R4 wrap lo", 0); rd(2, "R4 wrap hi", 0);
    // R5 nonvolatile gating
    wr(0, 8'h81); rd(0, "R9 ctrl nv", 8'h81);
    main_pwr = 0; pulse(3, 3); pulse(3, 3); cyc(3);
    rd(1, "R5 nv no supply", 0);
    main_pwr = 1; pulse(3, 3); cyc(3);
    rd(1, "R5 nv with supply", 1);
    wr(0, 8'h01); main_pwr = 0; pulse(3, 3); cyc(3);
    rd(1, "R5 battery no supply", 2);
    main_pwr = 1;
    // R6 forcing on poll enable
    wr(0, 8'h82); rd(0, "R6 forced ctrl", 8'h03);
    // R7 polled: glitchy rise counts once
    evt_in = 0; cyc(40);
    pulse(2, 2); evt_in = 1; cyc(40); evt_in = 0; cyc(40);
    rd(1, "R7 polled single count", 3);
    // R8 oscillator off stops polling
    osc_en = 0; evt_in = 1; cyc(60);
    rd(1, "R8 no poll with osc off", 3);
    osc_en = 1; cyc(40);
    rd(1, "R8 poll resumes", 4);
    evt_in = 0; cyc(40);
    // R9 map and masking
    wr(0, 8'hFF); rd(0, "R6 forced from FFh", 8'h03);
    wr(0, 8'h7C); rd(0, "R9 masked ctrl", 8'h00);
    rd(3, "R9 unused addr", 0);
    wr(1, 8'h34); wr(2, 8'h12);
    rd(1, "R9 cnt lo write", 8'h34); rd(2, "R9 cnt hi write", 8'h12);
    cyc(4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule